// File: doc/BRIEF.md
# I2C Crosspoint Control Slave

This block is the serial control front end for an 80-point analog switch matrix. It listens on a two-wire I2C bus in standard or fast mode. It oversamples SCL and SDA with a fast system clock and cleans up both lines with a synchronizer and a majority-free glitch filter. From the cleaned lines it recognises START and STOP conditions and decodes transfers addressed to its 7-bit device address.

A write carries exactly two payload bytes. Once both have been acknowledged, they are handed to the switch register block as one 16-bit word with a single-cycle strobe. A read returns exactly two bytes. The first is always zero. The second is the switch status byte of the currently selected row, which is captured from the register block when the read address is acknowledged.

The block pulls SDA low only through an open-drain enable. It never stretches the clock. It supports neither high-speed mode, general call nor 10-bit addressing.

Top module: `xpt_i2c_ctrl`

## Requirements
- R1: While and right after reset, `sda_drive_o` and `cmd_valid_o` are 0.
- R2: An address byte whose upper four bits are 1110 and lower three bits equal `addr_pins_i` is acknowledged: SDA is held low for the whole ninth SCL clock. Any other address is not acknowledged, and the block stays silent until the next START.
- R3: A write (R/W bit, the eighth bit, = 0) acknowledges two data bytes. After the ninth clock of the second byte ends, `cmd_valid_o` pulses and `cmd_word_o` = {first byte, second byte}. The first byte sits in bits 15:8: bit 15 is the switch state (1 = close), bits 14:11 are the row index and bits 10:8 are the column index. Bit 0 of the word is the load strobe (1 = apply all pending switch changes).
- R4: Data bytes written after the second byte are not acknowledged, and they produce no further command.
- R5: A read (R/W = 1) returns 0x00 first and then the `status_i` value captured at the address acknowledge. Both bytes are sent MSB first, and a 0 bit pulls SDA low. Bytes read past the second one return 0xFF, which means SDA stays released.
- R6: When the master does not acknowledge a read byte, SDA stays released until the next START.
- R7: A STOP or START before both write bytes are acknowledged discards the partial command. A START always releases SDA and begins a new address phase.
- R8: `sda_drive_o` changes only while SCL is low.
- R9: `cmd_valid_o` is high for exactly one clock per command.
- R10: A pulse on SCL shorter than three system clocks is ignored.
- R11: A repeated START after a write address phase starts a new transfer, which may be a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| addr_pins_i | input | 3 | Low three bits of the device address |
| status_i | input | 8 | Closed-switch status of the selected row, one bit per column |
| sda_drive_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| cmd_valid_o | output | 1 | One-cycle strobe for a completed command |
| cmd_word_o | output | 16 | Command word, valid with the strobe |

## Verification
The bound checker watches four things on every clock. It checks that SDA is driven only while SCL is low, that the command strobe lasts one cycle and falls in an SCL low phase, that any START or STOP leaves SDA released, and that reset leaves the outputs idle.

Only the bench scenarios can show the byte-level behaviour. These cover address matching and rejection, the field layout of the command word, and the acknowledge withheld on extra bytes. They also cover the captured status value, the 0xFF filler, the discarding of aborted writes, repeated START, and rejection of SCL glitches.

// File: rtl/xpt_i2c_pkg.sv
package xpt_i2c_pkg;
  localparam int          BYTE_W      = 8;
  localparam int          CMD_W       = 2 * BYTE_W;
  localparam logic [3:0]  DEV_ADDR_HI = 4'b1110;
  localparam logic [7:0]  RD_FIRST    = 8'h00;
  localparam logic [7:0]  RD_FILL     = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_RD_ACK
  } xpt_state_e;
endpackage

// File: rtl/xpt_i2c_filter.sv
module xpt_i2c_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic                   clean_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      win_q   <= '1;
      clean_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      // output moves only when the whole window agrees
      if (&win_q)       clean_q <= 1'b1;
      else if (~|win_q) clean_q <= 1'b0;
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/xpt_i2c_cond.sv
module xpt_i2c_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/xpt_i2c_fsm.sv
module xpt_i2c_fsm
  import xpt_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic [2:0]        addr_pins_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_drive_o,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_word_o
);
  localparam int              CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  xpt_state_e        st_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q, b0_q, tx_q, stat_q, next_byte;
  logic [1:0]        wr_idx_q, rd_idx_q;
  logic              rw_q, mack_q, drive_q, cmd_v_q;
  logic [CMD_W-1:0]  cmd_w_q;
  logic              addr_hit;

  assign addr_hit  = (shift_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_pins_i});
  assign next_byte = (rd_idx_q == 2'd1) ? stat_q : RD_FILL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      b0_q      <= '0;
      tx_q      <= '0;
      stat_q    <= '0;
      wr_idx_q  <= '0;
      rd_idx_q  <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      drive_q   <= 1'b0;
      cmd_v_q   <= 1'b0;
      cmd_w_q   <= '0;
    end else begin
      cmd_v_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        drive_q   <= 1'b0;
      end else if (stop_i) begin
        st_q    <= ST_IDLE;
        drive_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (rise_i) begin
              shift_q   <= {shift_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (fall_i && bit_cnt_q == CNT_FULL) begin
              if (addr_hit) begin
                st_q    <= ST_ACK_A;
                drive_q <= 1'b1;
                rw_q    <= shift_q[0];
                stat_q  <= status_i;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ACK_A: begin
            if (fall_i) begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                st_q     <= ST_RD;
                tx_q     <= RD_FIRST;
                drive_q  <= ~RD_FIRST[BYTE_W-1];
                rd_idx_q <= 2'd1;
              end else begin
                st_q     <= ST_WR;
                drive_q  <= 1'b0;
                wr_idx_q <= 2'd0;
              end
            end
          end
          ST_WR: begin
            if (rise_i) begin
              shift_q   <= {shift_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (fall_i && bit_cnt_q == CNT_FULL) begin
              if (wr_idx_q < 2'd2) begin
                st_q    <= ST_ACK_W;
                drive_q <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ACK_W: begin
            if (fall_i) begin
              st_q      <= ST_WR;
              drive_q   <= 1'b0;
              bit_cnt_q <= '0;
              wr_idx_q  <= wr_idx_q + 1'b1;
              if (wr_idx_q == 2'd0) begin
                b0_q <= shift_q;
              end else begin
                cmd_w_q <= {b0_q, shift_q};
                cmd_v_q <= 1'b1;
              end
            end
          end
          ST_RD: begin
            if (fall_i) begin
              if (bit_cnt_q == CNT_LAST) begin
                st_q    <= ST_RD_ACK;
                drive_q <= 1'b0;
              end else begin
                tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                drive_q   <= ~tx_q[BYTE_W-2];
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (rise_i) begin
              mack_q <= ~sda_i;
            end else if (fall_i) begin
              if (mack_q) begin
                st_q      <= ST_RD;
                tx_q      <= next_byte;
                drive_q   <= ~next_byte[BYTE_W-1];
                bit_cnt_q <= '0;
                if (rd_idx_q < 2'd2) rd_idx_q <= rd_idx_q + 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_drive_o = drive_q;
  assign cmd_valid_o = cmd_v_q;
  assign cmd_word_o  = cmd_w_q;
endmodule

// File: rtl/xpt_i2c_ctrl.sv
module xpt_i2c_ctrl
  import xpt_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        addr_pins_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_drive_o,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_word_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic start_p, stop_p, rise_p, fall_p;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    xpt_i2c_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_lines[g]),
      .clean_o(clean_lines[g])
    );
  end

  xpt_i2c_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (clean_lines[1]),
    .sda_i  (clean_lines[0]),
    .start_o(start_p),
    .stop_o (stop_p),
    .rise_o (rise_p),
    .fall_o (fall_p)
  );

  xpt_i2c_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .rise_i     (rise_p),
    .fall_i     (fall_p),
    .sda_i      (clean_lines[0]),
    .addr_pins_i(addr_pins_i),
    .status_i   (status_i),
    .sda_drive_o(sda_drive_o),
    .cmd_valid_o(cmd_valid_o),
    .cmd_word_o (cmd_word_o)
  );
endmodule

// File: rtl/xpt_i2c_chk.sv
module xpt_i2c_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_drive_o,
  input logic cmd_valid_o,
  input logic start_p,
  input logic stop_p
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!sda_drive_o && !cmd_valid_o));

  assert_drive_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_drive_o) |-> !scl_i);

  assert_cmd_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_cmd_scl_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !scl_i);

  assert_start_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p |=> !sda_drive_o);

  assert_stop_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_p |=> !sda_drive_o);
endmodule

bind xpt_i2c_ctrl xpt_i2c_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_drive_o(sda_drive_o),
  .cmd_valid_o(cmd_valid_o),
  .start_p    (start_p),
  .stop_p     (stop_p)
);

// File: tb/xpt_i2c_ctrl_test.sv
`timescale 1ns/1ps
module xpt_i2c_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        sda_bus;
  logic [2:0]  pins = 3'b101;
  logic [7:0]  status = 8'h00;
  logic        drv, cv;
  logic [15:0] cw;

  int          n_chk = 0, n_fail = 0, n_cmd = 0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~drv;

  xpt_i2c_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_pins_i(pins), .status_i(status),
    .sda_drive_o(drv), .cmd_valid_o(cv), .cmd_word_o(cw)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: every clock, a strobe must match the next expected command
  always @(negedge clk) begin
    if (rst_ni && cv) begin
      n_cmd++;
      if (exp_q.size() == 0) chk(1'b0, "R4 R7 unexpected command", {16'h0, cw}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(cw == e, "R3 command word", {16'h0, cw}, {16'h0, e});
      end
    end
  end

  task automatic q();
    repeat (10) @(posedge clk);
    #2;
  endtask

  task automatic bit_io(input logic b, output logic seen);
    m_sda = b; q();
    m_scl = 1'b1; q();
    seen = sda_bus; q();
    m_scl = 1'b0; q();
  endtask

  task automatic start_cond();
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    m_sda = 1'b0; q();
    m_scl = 1'b0; q();
  endtask

  task automatic stop_cond();
    m_sda = 1'b0; q();
    m_scl = 1'b1; q();
    m_sda = 1'b1; q(); q();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(v[i], s);
    bit_io(1'b1, s);
    acked = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
    end
    bit_io(~mack, s);
  endtask

  task automatic glitch();
    m_scl = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    m_scl = 1'b0; q();
  endtask

  initial begin
    logic       a;
    logic [7:0] rv;
    int         c0;
    logic       s;

    repeat (3) @(posedge clk);
    #2;
    chk(drv == 1'b0 && cv == 1'b0, "R1 outputs in reset", {drv, cv}, 0);
    rst_ni = 1'b1;
    q();
    chk(drv == 1'b0 && cv == 1'b0, "R1 outputs after reset", {drv, cv}, 0);

    // basic write
    exp_q.push_back(16'hA501);
    start_cond();
    wr_byte(8'hEA, a); chk(a, "R2 address ack", a, 1);
    wr_byte(8'hA5, a); chk(a, "R3 first byte ack", a, 1);
    wr_byte(8'h01, a); chk(a, "R3 second byte ack", a, 1);
    stop_cond();

    // write with an SCL glitch after the address
    exp_q.push_back(16'h3CFE);
    start_cond();
    wr_byte(8'hEA, a); chk(a, "R10 address ack", a, 1);
    glitch();
    wr_byte(8'h3C, a); chk(a, "R10 first byte ack", a, 1);
    wr_byte(8'hFE, a); chk(a, "R10 second byte ack", a, 1);
    stop_cond();
    chk(exp_q.size() == 0, "R10 glitch-free command delivered", exp_q.size(), 0);

    // wrong low bits, wrong high bits
    c0 = n_cmd;
    start_cond();
    wr_byte(8'hE4, a); chk(!a, "R2 low-bit mismatch no ack", a, 0);
    wr_byte(8'h11, a); chk(!a, "R2 silent after mismatch", a, 0);
    wr_byte(8'h22, a); chk(!a, "R2 silent after mismatch", a, 0);
    stop_cond();
    start_cond();
    wr_byte(8'h7A, a); chk(!a, "R2 high-bit mismatch no ack", a, 0);
    stop_cond();
    chk(n_cmd == c0, "R2 no command on mismatch", n_cmd, c0);

    // other pin setting
    pins = 3'b000;
    exp_q.push_back(16'h0000);
    start_cond();
    wr_byte(8'hE0, a); chk(a, "R2 address ack pins 000", a, 1);
    wr_byte(8'h00, a); chk(a, "R3 byte ack", a, 1);
    wr_byte(8'h00, a); chk(a, "R3 byte ack", a, 1);
    stop_cond();
    pins = 3'b101;

    // extra bytes
    c0 = n_cmd;
    exp_q.push_back(16'hFF80);
    start_cond();
    wr_byte(8'hEA, a);
    wr_byte(8'hFF, a);
    wr_byte(8'h80, a);
    wr_byte(8'h55, a); chk(!a, "R4 third byte not acked", a, 0);
    wr_byte(8'hAA, a); chk(!a, "R4 fourth byte not acked", a, 0);
    stop_cond();
    chk(n_cmd == c0 + 1, "R4 exactly one command", n_cmd, c0 + 1);

    // abort by STOP mid second byte
    c0 = n_cmd;
    start_cond();
    wr_byte(8'hEA, a);
    wr_byte(8'h77, a); chk(a, "R7 first byte ack", a, 1);
    bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s);
    stop_cond();
    chk(n_cmd == c0, "R7 STOP discards partial command", n_cmd, c0);

    // START mid-byte, then read with status capture
    start_cond();
    wr_byte(8'hEA, a);
    bit_io(1'b0, s); bit_io(1'b1, s); bit_io(1'b1, s); bit_io(1'b0, s);
    status = 8'h5A;
    start_cond();
    wr_byte(8'hEB, a); chk(a, "R7 read address ack after mid-byte START", a, 1);
    status = 8'h33;
    rd_byte(1'b1, rv); chk(rv == 8'h00, "R5 first read byte zero", rv, 8'h00);
    rd_byte(1'b0, rv); chk(rv == 8'h5A, "R5 captured status", rv, 8'h5A);
    chk(drv == 1'b0, "R6 released after NACK", drv, 0);
    bit_io(1'b1, s); chk(s == 1'b1, "R6 SDA free after NACK", s, 1);
    stop_cond();
    chk(n_cmd == c0, "R7 START discards partial command", n_cmd, c0);

    // read past the second byte
    status = 8'hC3;
    start_cond();
    wr_byte(8'hEB, a); chk(a, "R5 read address ack", a, 1);
    rd_byte(1'b1, rv); chk(rv == 8'h00, "R5 first byte", rv, 8'h00);
    rd_byte(1'b1, rv); chk(rv == 8'hC3, "R5 status byte", rv, 8'hC3);
    rd_byte(1'b1, rv); chk(rv == 8'hFF, "R5 filler byte", rv, 8'hFF);
    rd_byte(1'b0, rv); chk(rv == 8'hFF, "R5 filler byte", rv, 8'hFF);
    stop_cond();

    // repeated START after write address
    status = 8'h81;
    c0 = n_cmd;
    start_cond();
    wr_byte(8'hEA, a);
    start_cond();
    wr_byte(8'hEB, a); chk(a, "R11 repeated START read ack", a, 1);
    rd_byte(1'b1, rv); chk(rv == 8'h00, "R11 first byte", rv, 8'h00);
    rd_byte(1'b0, rv); chk(rv == 8'h81, "R11 status byte", rv, 8'h81);
    stop_cond();
    chk(n_cmd == c0, "R11 no command", n_cmd, c0);

    // read to another device leaves the bus alone
    start_cond();
    wr_byte(8'hE7, a); chk(!a, "R2 foreign read not acked", a, 0);
    rd_byte(1'b0, rv); chk(rv == 8'hFF, "R2 foreign read bus idle", rv, 8'hFF);
    stop_cond();

    q(); q();
    chk(exp_q.size() == 0, "R3 all commands delivered", exp_q.size(), 0);
    chk(cv == 1'b0, "R9 strobe idle", cv, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule